// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is a single channel of a scatter-gather DMA engine that moves buffers from a word-addressed memory onto an outbound data stream. Software builds linked 16-word descriptors in memory. While the channel is halted it loads the first descriptor's address into the current-pointer register. It then sets run and writes the address of the last descriptor it wants handled into the tail register. The tail write is what starts the work.

For each descriptor the engine reads the link, buffer and control words. It streams the buffer out one 32-bit word per cycle, writes a completion word back into the descriptor, raises a completion flag and advances the current pointer along the link. It stops after the descriptor whose address equals the tail. Clearing run lets the descriptor in flight finish and then parks the channel. A soft reset abandons all activity at once and returns the register bank to its defaults.

Top module: `dmach_channel`

## Requirements
- R1: After reset the control register (offset 0x00) reads 0, the status register (0x04) reads 0x1 (halted), the current pointer (0x08) and the tail pointer (0x10) read 0, and any other offset reads 0.
- R2: Writing control bit 0 (run) as 1 clears status bit 0 (halted) within two cycles. Writing it as 0 while the engine is idle sets halted again.
- R3: A write to the current pointer takes effect only while halted. While running, the write is ignored and the register keeps its value.
- R4: A tail write made while run is set starts processing at the current pointer. The engine follows the link in descriptor word 0 and handles every descriptor up to and including the one whose address equals the tail. Word 2 holds the buffer byte address and word 6 holds the control word.
- R5: The byte length is control bits 15:0. The engine streams ceil(length/4) words from the buffer in ascending address order. It flags the first word when control bit 27 is set and the final word when control bit 26 is set.
- R6: After a descriptor's data, the engine writes 0x8000_0000 OR the byte length to descriptor word 7. The current pointer then takes the link value.
- R7: Every finished descriptor sets status bit 12. Finishing the tail descriptor also sets status bit 13. Writing a 1 to either bit clears it, and writing 0 leaves it unchanged.
- R8: A descriptor that links to itself and is also the tail is processed exactly once per tail write.
- R9: A zero-length descriptor produces no stream words and is still completed, with 0x8000_0000 written to word 7.
- R10: Clearing run during a descriptor lets that descriptor complete with its writeback. No further descriptor is started, and halted then reads 1.
- R11: Writing control bit 2 stops all memory and stream activity from the next cycle. Control bit 2 reads 1 for RST_CYCLES cycles and then 0, after which every register holds its R1 value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when 1, read when 0 |
| mem_addr | output | MEM_AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read request |
| st_valid | output | 1 | Stream word valid |
| st_data | output | 32 | Stream word |
| st_first | output | 1 | First word of a frame |
| st_last | output | 1 | Final word of a frame |

## Verification
The chain test uses three linked descriptors of 8, 5 and 12 bytes. The 5-byte length shows whether a partial final word is rounded up, and the flag bits placed only on the outer descriptors show whether first and last marking follows the control word or the chain position. A self-linked descriptor, written as tail twice, separates a stop on pointer equality from one that loops or stops early. A zero-length descriptor shows whether the move phase is skipped while the writeback still happens. Clearing run during a two-descriptor chain and soft-resetting in the middle of a long move show the difference between a graceful stop and an immediate abort, through the writeback words, the pointer and the count of stream words.

// File: rtl/dmach_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the descriptor-chained DMA channel.
// Assumes 32-bit register and memory words and 16-word descriptors.
package dmach_pkg;
    localparam int WORD_W = 32;

    // Register byte offsets inside the channel bank
    localparam logic [4:0] OFF_CTL  = 5'h00;
    localparam logic [4:0] OFF_STS  = 5'h04;
    localparam logic [4:0] OFF_CUR  = 5'h08;
    localparam logic [4:0] OFF_TAIL = 5'h10;

    // Register bit positions
    localparam int CTL_RUN   = 0;
    localparam int CTL_SRST  = 2;
    localparam int STS_HALT  = 0;
    localparam int STS_CMPL  = 12;
    localparam int STS_DRAIN = 13;

    // Descriptor word indices and control/status bits
    localparam int DW_LINK = 0;
    localparam int DW_BUF  = 2;
    localparam int DW_CTL  = 6;
    localparam int DW_DONE = 7;
    localparam int DC_SOF  = 27;
    localparam int DC_EOF  = 26;
    localparam int DS_DONE = 31;

    typedef enum logic [2:0] {
        E_IDLE, E_RD_LINK, E_RD_BUF, E_RD_CTL, E_PARSE, E_MOVE, E_DRAIN, E_WBACK
    } eng_state_t;
endpackage

// File: rtl/dmach_regs.sv
`timescale 1ns/1ps
// Register bank of one DMA channel: run/stop, soft reset countdown, halted
// status, write-one-to-clear interrupt flags, current and tail pointers and
// the pending-work flag that a tail write arms.
// Assumes desc_done is a one-cycle pulse and next_ptr is valid with it.
module dmach_regs #(
    parameter int RST_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [4:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        eng_idle,
    input  logic        desc_done,
    input  logic [31:0] next_ptr,
    output logic        eng_start,
    output logic [31:0] cur_ptr,
    output logic        eng_flush,
    output logic        resetting
);
    import dmach_pkg::*;

    localparam int RC_W = $clog2(RST_CYCLES + 1);

    logic            run_q, halted_q, work_q, cmpl_q, drain_q;
    logic [31:0]     cur_q, tail_q;
    logic [RC_W-1:0] rst_cnt;
    logic            wr_ctl, wr_sts, wr_cur, wr_tail, soft_go, at_tail;

    assign resetting = (rst_cnt != '0);
    assign wr_ctl    = reg_we && !resetting && (reg_addr == OFF_CTL);
    assign wr_sts    = reg_we && !resetting && (reg_addr == OFF_STS);
    assign wr_cur    = reg_we && !resetting && (reg_addr == OFF_CUR);
    assign wr_tail   = reg_we && !resetting && (reg_addr == OFF_TAIL);
    assign soft_go   = wr_ctl && reg_wdata[CTL_SRST];
    assign at_tail   = (cur_q == tail_q);
    assign eng_flush = soft_go || resetting;
    assign eng_start = work_q && run_q;
    assign cur_ptr   = cur_q;

    // Register state: defaults on either reset, otherwise software and engine updates
    always_ff @(posedge clk) begin
        if (!rst_n || soft_go || resetting) begin
            run_q    <= 1'b0;
            halted_q <= 1'b1;
            work_q   <= 1'b0;
            cmpl_q   <= 1'b0;
            drain_q  <= 1'b0;
            cur_q    <= '0;
            tail_q   <= '0;
            if (!rst_n)       rst_cnt <= '0;
            else if (soft_go) rst_cnt <= RC_W'(RST_CYCLES);
            else              rst_cnt <= rst_cnt - 1'b1;
        end else begin
            if (wr_ctl) run_q <= reg_wdata[CTL_RUN];

            if (run_q)         halted_q <= 1'b0;
            else if (eng_idle) halted_q <= 1'b1;

            if (wr_cur && halted_q) cur_q <= reg_wdata;
            else if (desc_done)     cur_q <= next_ptr;

            if (wr_tail) tail_q <= reg_wdata;

            if (wr_tail && run_q)           work_q <= 1'b1;
            else if (desc_done && at_tail)  work_q <= 1'b0;

            if (desc_done)                          cmpl_q <= 1'b1;
            else if (wr_sts && reg_wdata[STS_CMPL]) cmpl_q <= 1'b0;

            if (desc_done && at_tail)                drain_q <= 1'b1;
            else if (wr_sts && reg_wdata[STS_DRAIN]) drain_q <= 1'b0;
        end
    end

    // Read multiplexer over the mapped offsets
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_CTL: begin
                reg_rdata[CTL_RUN]  = run_q;
                reg_rdata[CTL_SRST] = resetting;
            end
            OFF_STS: begin
                reg_rdata[STS_HALT]  = halted_q;
                reg_rdata[STS_CMPL]  = cmpl_q;
                reg_rdata[STS_DRAIN] = drain_q;
            end
            OFF_CUR:  reg_rdata = cur_q;
            OFF_TAIL: reg_rdata = tail_q;
            default:  reg_rdata = '0;
        endcase
    end

    AST_HALT_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        halted_q |-> eng_idle) else $error("halted while engine active"); // R2
    AST_CUR_HELD_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted_q && !desc_done && !soft_go) |=> $stable(cur_q)) else $error("cur moved while running"); // R3
    AST_CMPL_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_done && !soft_go) |=> cmpl_q) else $error("completion flag missing"); // R7
    AST_RESET_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        resetting |-> (!run_q && halted_q)) else $error("run during soft reset"); // R11
endmodule

// File: rtl/dmach_engine.sv
`timescale 1ns/1ps
// Descriptor engine: fetches the link, buffer and control words of the
// descriptor at the current pointer, streams the buffer words out,
// writes the completion word back and pulses desc_done.
// Assumes the memory returns read data exactly one cycle after a request
// and that the stream sink accepts a word every cycle.
module dmach_engine #(
    parameter int MEM_AW = 16,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              start,
    input  logic [MEM_AW-1:0] cur_word,
    output logic              idle,
    output logic              desc_done,
    output logic [31:0]       next_ptr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              st_valid,
    output logic [31:0]       st_data,
    output logic              st_first,
    output logic              st_last
);
    import dmach_pkg::*;

    eng_state_t        state;
    logic [MEM_AW-1:0] dbase, bufw;
    logic [31:0]       link_q;
    logic [LEN_W-1:0]  len_q, words_q, rd_idx, out_idx, words_c;
    logic              sof_q, eof_q, rvalid_q;
    logic [LEN_W:0]    len_sum;

    assign len_sum = {1'b0, mem_rdata[LEN_W-1:0]} + (LEN_W+1)'(3);
    assign words_c = len_sum[LEN_W:2];

    // Sequencer: fetch, move, writeback; flush returns it to idle at once
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            state    <= E_IDLE;
            dbase    <= '0;
            bufw     <= '0;
            link_q   <= '0;
            len_q    <= '0;
            words_q  <= '0;
            rd_idx   <= '0;
            out_idx  <= '0;
            sof_q    <= 1'b0;
            eof_q    <= 1'b0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= (state == E_MOVE);
            if (rvalid_q) out_idx <= out_idx + 1'b1;
            case (state)
                E_IDLE: if (start) begin
                    dbase <= cur_word;
                    state <= E_RD_LINK;
                end
                E_RD_LINK: state <= E_RD_BUF;
                E_RD_BUF: begin
                    link_q <= mem_rdata;
                    state  <= E_RD_CTL;
                end
                E_RD_CTL: begin
                    bufw  <= mem_rdata[MEM_AW+1:2];
                    state <= E_PARSE;
                end
                E_PARSE: begin
                    len_q   <= mem_rdata[LEN_W-1:0];
                    sof_q   <= mem_rdata[DC_SOF];
                    eof_q   <= mem_rdata[DC_EOF];
                    words_q <= words_c;
                    rd_idx  <= '0;
                    out_idx <= '0;
                    state   <= (words_c == '0) ? E_WBACK : E_MOVE;
                end
                E_MOVE: begin
                    rd_idx <= rd_idx + 1'b1;
                    if (rd_idx == words_q - 1'b1) state <= E_DRAIN;
                end
                E_DRAIN: state <= E_WBACK;
                E_WBACK: state <= E_IDLE;
                default: state <= E_IDLE;
            endcase
        end
    end

    // Memory port request decode from the sequencer state
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = dbase;
        mem_wdata = '0;
        mem_wdata[DS_DONE]   = 1'b1;
        mem_wdata[LEN_W-1:0] = len_q;
        case (state)
            E_RD_LINK: mem_addr = dbase + MEM_AW'(DW_LINK);
            E_RD_BUF:  mem_addr = dbase + MEM_AW'(DW_BUF);
            E_RD_CTL:  mem_addr = dbase + MEM_AW'(DW_CTL);
            E_MOVE:    mem_addr = bufw + MEM_AW'(rd_idx);
            E_WBACK: begin
                mem_we   = 1'b1;
                mem_addr = dbase + MEM_AW'(DW_DONE);
            end
            default:   mem_req = 1'b0;
        endcase
    end

    assign idle      = (state == E_IDLE);
    assign desc_done = (state == E_WBACK);
    assign next_ptr  = link_q;
    assign st_valid  = rvalid_q;
    assign st_data   = mem_rdata;
    assign st_first  = rvalid_q && sof_q && (out_idx == '0);
    assign st_last   = rvalid_q && eof_q && (out_idx == words_q - 1'b1);

    AST_STREAM_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n || flush)
        st_valid |-> $past(state == E_MOVE)) else $error("stream word without read"); // R5
    AST_WBACK_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n || flush)
        (state == E_WBACK) |-> !st_valid) else $error("writeback before data drained"); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n || flush)
        desc_done |=> !desc_done) else $error("double completion"); // R8
endmodule

// File: rtl/dmach_channel.sv
`timescale 1ns/1ps
// Top of one descriptor-chained DMA channel: register bank plus the
// descriptor engine. Memory is word addressed; pointers are byte addresses
// whose low two bits are ignored by the engine.
module dmach_channel #(
    parameter int MEM_AW     = 16,
    parameter int LEN_W      = 16,
    parameter int RST_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [4:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              st_valid,
    output logic [31:0]       st_data,
    output logic              st_first,
    output logic              st_last
);
    logic        eng_idle, desc_done, eng_start, eng_flush, resetting;
    logic [31:0] next_ptr, cur_ptr;

    dmach_regs #(.RST_CYCLES(RST_CYCLES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .eng_idle  (eng_idle),
        .desc_done (desc_done),
        .next_ptr  (next_ptr),
        .eng_start (eng_start),
        .cur_ptr   (cur_ptr),
        .eng_flush (eng_flush),
        .resetting (resetting)
    );

    dmach_engine #(.MEM_AW(MEM_AW), .LEN_W(LEN_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (eng_flush),
        .start     (eng_start),
        .cur_word  (cur_ptr[MEM_AW+1:2]),
        .idle      (eng_idle),
        .desc_done (desc_done),
        .next_ptr  (next_ptr),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .st_valid  (st_valid),
        .st_data   (st_data),
        .st_first  (st_first),
        .st_last   (st_last)
    );

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        resetting |-> (!mem_req && !st_valid)) else $error("activity during soft reset"); // R11
endmodule

// File: tb/sim_dmach_channel.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module sim_dmach_channel;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        st_valid, st_first, st_last;
    logic [31:0] st_data;

    int checks = 0;
    int errors = 0;
    int n_req = 0;
    int n_wr = 0;
    int cap_n = 0;
    logic [31:0] mem [0:1023];
    logic [31:0] cap_d [0:63];
    logic        cap_f [0:63];
    logic        cap_l [0:63];

    always #2.5 clk = ~clk;

    dmach_channel u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .st_valid(st_valid), .st_data(st_data),
        .st_first(st_first), .st_last(st_last)
    );

    // Memory model with one-cycle read latency
    always @(posedge clk) begin
        if (mem_req) begin
            n_req = n_req + 1;
            if (mem_we) begin
                mem[mem_addr[9:0]] = mem_wdata;
                n_wr = n_wr + 1;
            end else begin
                mem_rdata <= mem[mem_addr[9:0]];
            end
        end
    end

    // Stream capture away from the active edge
    always @(negedge clk) begin
        if (st_valid) begin
            if (cap_n < 64) begin
                cap_d[cap_n] = st_data;
                cap_f[cap_n] = st_first;
                cap_l[cap_n] = st_last;
            end
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_sts(input int bitn, input logic val, input string req);
        logic [31:0] s;
        bit ok = 0;
        for (int i = 0; i < 400; i++) begin
            rd(5'h04, s);
            if (s[bitn] == val) begin ok = 1; break; end
        end
        chk(req, 32'(ok), 32'd1);
    endtask

    task automatic put_desc(input int a, input logic [31:0] lnk, input logic [31:0] buff,
                            input logic [31:0] ctl);
        mem[(a >> 2) + 0] = lnk;
        mem[(a >> 2) + 2] = buff;
        mem[(a >> 2) + 6] = ctl;
        mem[(a >> 2) + 7] = 32'h0;
    endtask

    task automatic fill(input int buff, input int nw);
        for (int i = 0; i < nw; i++) mem[(buff >> 2) + i] = 32'hA000_0000 | ((buff >> 2) + i);
    endtask

    task automatic load_cur(input logic [31:0] p);
        wr(5'h00, 32'h0);
        wait_sts(0, 1'b1, "R10 halt before load");
        wr(5'h08, p);
        wr(5'h00, 32'h1);
        wr(5'h04, 32'h3000);
        cap_n = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(5'h00, v); chk("R1 control", v, 32'h0);
        rd(5'h04, v); chk("R1 status", v, 32'h1);
        rd(5'h08, v); chk("R1 cur", v, 32'h0);
        rd(5'h10, v); chk("R1 tail", v, 32'h0);
        rd(5'h0C, v); chk("R1 unmapped", v, 32'h0);
    endtask

    task automatic t_run_cur();
        logic [31:0] v;
        wr(5'h08, 32'h0000_0100);
        rd(5'h08, v); chk("R3 cur while halted", v, 32'h100);
        wr(5'h00, 32'h1);
        @(negedge clk);
        rd(5'h04, v); chk("R2 halted clears", v & 32'h1, 32'h0);
        wr(5'h08, 32'h0000_0999);
        rd(5'h08, v); chk("R3 cur ignored while running", v, 32'h100);
        wr(5'h00, 32'h0);
        @(negedge clk);
        rd(5'h04, v); chk("R2 halted sets", v & 32'h1, 32'h1);
    endtask

    task automatic t_chain();
        logic [31:0] v;
        put_desc(32'h100, 32'h140, 32'h400, 32'h0800_0008);
        put_desc(32'h140, 32'h180, 32'h420, 32'h0000_0005);
        put_desc(32'h180, 32'h1C0, 32'h440, 32'h0400_000C);
        fill(32'h400, 2); fill(32'h420, 2); fill(32'h440, 3);
        load_cur(32'h100);
        wr(5'h10, 32'h180);
        wait_sts(13, 1'b1, "R7 chain drained flag");
        chk("R4 word count", 32'(cap_n), 32'd7);
        chk("R5 w0", cap_d[0], 32'hA000_0100);
        chk("R5 w1", cap_d[1], 32'hA000_0101);
        chk("R5 w2 partial rounds up", cap_d[2], 32'hA000_0108);
        chk("R5 w3", cap_d[3], 32'hA000_0109);
        chk("R5 w6", cap_d[6], 32'hA000_0112);
        chk("R5 first flag", {cap_f[0], cap_f[1], cap_f[2], cap_f[4]}, 32'h8);
        chk("R5 last flag", {cap_l[1], cap_l[3], cap_l[5], cap_l[6]}, 32'h1);
        chk("R6 wb d0", mem[(32'h100 >> 2) + 7], 32'h8000_0008);
        chk("R6 wb d1", mem[(32'h140 >> 2) + 7], 32'h8000_0005);
        chk("R6 wb d2", mem[(32'h180 >> 2) + 7], 32'h8000_000C);
        rd(5'h08, v); chk("R6 cur follows link", v, 32'h1C0);
        rd(5'h04, v); chk("R7 both flags", v & 32'h3000, 32'h3000);
        wr(5'h04, 32'h0);
        rd(5'h04, v); chk("R7 zero write keeps", v & 32'h3000, 32'h3000);
        wr(5'h04, 32'h1000);
        rd(5'h04, v); chk("R7 clear bit12 only", v & 32'h3000, 32'h2000);
        wr(5'h04, 32'h2000);
        rd(5'h04, v); chk("R7 clear bit13", v & 32'h3000, 32'h0);
    endtask

    task automatic t_selflink();
        logic [31:0] v;
        int w0;
        put_desc(32'h200, 32'h200, 32'h480, 32'h0C00_0004);
        fill(32'h480, 1);
        load_cur(32'h200);
        w0 = n_wr;
        wr(5'h10, 32'h200);
        wait_sts(13, 1'b1, "R8 self-link finishes");
        repeat (30) @(negedge clk);
        chk("R8 one word per tail write", 32'(cap_n), 32'd1);
        chk("R8 one writeback", 32'(n_wr - w0), 32'd1);
        rd(5'h08, v); chk("R8 cur stays", v, 32'h200);
        wr(5'h04, 32'h3000);
        wr(5'h10, 32'h200);
        wait_sts(13, 1'b1, "R8 second tail write");
        repeat (30) @(negedge clk);
        chk("R8 second pass once", 32'(cap_n), 32'd2);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        put_desc(32'h240, 32'h280, 32'h4C0, 32'h0C00_0000);
        load_cur(32'h240);
        wr(5'h10, 32'h240);
        wait_sts(13, 1'b1, "R9 zero length completes");
        chk("R9 no stream words", 32'(cap_n), 32'd0);
        chk("R9 writeback", mem[(32'h240 >> 2) + 7], 32'h8000_0000);
        rd(5'h08, v); chk("R9 cur advanced", v, 32'h280);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        put_desc(32'h300, 32'h340, 32'h600, 32'h0C00_0028);
        put_desc(32'h340, 32'h380, 32'h640, 32'h0C00_0028);
        fill(32'h600, 10); fill(32'h640, 10);
        load_cur(32'h300);
        wr(5'h10, 32'h340);
        repeat (4) @(negedge clk);
        wr(5'h00, 32'h0);
        wait_sts(0, 1'b1, "R10 halts after descriptor");
        chk("R10 first finished", mem[(32'h300 >> 2) + 7], 32'h8000_0028);
        chk("R10 second untouched", mem[(32'h340 >> 2) + 7], 32'h0);
        chk("R10 words of first only", 32'(cap_n), 32'd10);
        rd(5'h08, v); chk("R10 cur at second", v, 32'h340);
        rd(5'h04, v); chk("R10 flags", v & 32'h3000, 32'h1000);
    endtask

    task automatic t_softrst();
        logic [31:0] v;
        int r0;
        put_desc(32'h380, 32'h3C0, 32'h800, 32'h0C00_00C8);
        fill(32'h800, 50);
        load_cur(32'h380);
        wr(5'h10, 32'h380);
        repeat (12) @(negedge clk);
        wr(5'h00, 32'h4);
        rd(5'h00, v); chk("R11 reset bit busy", v & 32'h4, 32'h4);
        r0 = n_req;
        for (int i = 0; i < 40; i++) begin
            rd(5'h00, v);
            if (v[2] == 1'b0) break;
        end
        chk("R11 reset bit clears", v, 32'h0);
        chk("R11 no memory activity", 32'(n_req - r0), 32'd0);
        chk("R11 move aborted", 32'(cap_n < 50 && cap_n > 0), 32'd1);
        chk("R11 no writeback", mem[(32'h380 >> 2) + 7], 32'h0);
        rd(5'h04, v); chk("R11 status default", v, 32'h1);
        rd(5'h08, v); chk("R11 cur default", v, 32'h0);
        rd(5'h10, v); chk("R11 tail default", v, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_run_cur();
        t_chain();
        t_selflink();
        t_zero();
        t_stop();
        t_softrst();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule